// File: doc/BRIEF.md
# Nibble RAM Address Register Unit

This block holds the data-memory address of a small 4-bit processor. The address register is built from three nibbles: a high nibble, a middle nibble and a low nibble. The instruction decoder drives one strobe per operation. The block then loads, swaps, increments, decrements or XOR-modifies the nibbles. It also reports a skip request when an operation's condition holds, and it drives the RAM address bus.

The accumulator and the X register live outside the block. They enter as input ports. When a swap operation moves a nibble back to one of them, the old nibble is returned on a data port together with a write-enable.

A one-shot operation zeroes the upper lines of the address bus for exactly one cycle. During that cycle the low nibble still drives the bottom lines, and the register itself is left unchanged.

Top module: `nram_addr_unit`

## Requirements
- R1: While reset is held low and in the cycle after it is released, `b_out`, `ram_addr` and `skip_req` are all zero. The register bit layout is: bits 11:8 high nibble, bits 7:4 middle nibble, bits 3:0 low nibble.
- R2: `op_load_pair` places `load_word` into bits 7:0 at the next edge and clears the high nibble, whatever the high nibble held before.
- R3: `op_xor_mid` XORs middle-nibble bits 2:0 with `imm` bits 2:0. Middle-nibble bit 3, `imm` bit 3, the low nibble and the high nibble are all left as they are.
- R4: `op_inc_low` adds one to the low nibble modulo 16, with no carry into the middle nibble. `skip_req` is high in the strobe cycle exactly when the new low nibble is 0000.
- R5: `op_dec_low` subtracts one from the low nibble modulo 16. `skip_req` is high exactly when the new value is 1111. When `op_xor_mid` is strobed in the same cycle, both updates are committed together.
- R6: `op_cmp_low` raises `skip_req` in the strobe cycle exactly when the low nibble equals `imm`, and it leaves the register unchanged.
- R7: In the one cycle after `op_zero_page`, `ram_addr` bits 11:4 are zero and bits 3:0 equal the low nibble. The register is not changed, and in the cycle after that the bus follows the register again.
- R8: Outside the cycle after `op_zero_page`, `ram_addr` equals `b_out`.
- R9: `op_bu_from_acc` loads the high nibble from `acc_in`. `op_bm_from_x` loads the middle nibble from `x_in`.
- R10: `op_bm_swap_x` loads the middle nibble from `x_in` and returns the old middle nibble on `x_out`, with `x_we` high in that cycle. `op_bl_swap_acc` does the same for the low nibble, using `acc_in`, `acc_out` and `acc_we`.
- R11: `skip_req`, `acc_we` and `x_we` are single-cycle signals. They are low in every cycle where their causing strobe is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_load_pair | input | 1 | Load bits 7:0, clear high nibble |
| op_bu_from_acc | input | 1 | High nibble from accumulator |
| op_bm_from_x | input | 1 | Middle nibble from X |
| op_bm_swap_x | input | 1 | Swap middle nibble and X |
| op_bl_swap_acc | input | 1 | Swap low nibble and accumulator |
| op_xor_mid | input | 1 | XOR middle bits 2:0 with immediate |
| op_inc_low | input | 1 | Increment low nibble, skip on 0000 |
| op_dec_low | input | 1 | Decrement low nibble, skip on 1111 |
| op_cmp_low | input | 1 | Skip if low nibble equals immediate |
| op_zero_page | input | 1 | Zero upper bus lines next cycle |
| load_word | input | 8 | Value for a pair load |
| imm | input | 4 | Immediate field |
| acc_in | input | 4 | Accumulator value |
| x_in | input | 4 | X register value |
| b_out | output | 12 | Current address register |
| ram_addr | output | 12 | RAM address bus |
| skip_req | output | 1 | Skip request pulse |
| acc_out | output | 4 | Old low nibble for the accumulator |
| acc_we | output | 1 | Accumulator write-enable |
| x_out | output | 4 | Old middle nibble for X |
| x_we | output | 1 | X write-enable |

## Verification
The hardest state to reach is an override cycle that overlaps another update. In that cycle the bus must show the low nibble as it was before the update, and the next cycle must show the whole updated register.

The stimulus sets the high nibble to a nonzero value, then strobes `op_zero_page`, and then issues an increment in the override cycle itself. The same stimulus also drives the low nibble through both wrap points: first set to 1111 by a swap and incremented, then brought back to 0000 and decremented. It combines a decrement with an XOR, and it uses an immediate whose unused top bit is set.

// File: rtl/nram_addr_pkg.sv
package nram_addr_pkg;

   // register-move strobes, applied in field order (later fields win)
   typedef struct packed {
      logic load;
      logic bu_acc;
      logic bm_x;
      logic bm_swap;
      logic bl_swap;
   } nra_move_t;

   // arithmetic / test strobes
   typedef struct packed {
      logic xor_mid;
      logic inc;
      logic dec;
      logic cmp;
   } nra_step_t;

endpackage

// File: rtl/nra_move_stage.sv
module nra_move_stage
   import nram_addr_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3
) (
   input  logic [NIB_W*NUM_NIB-1:0] b_cur,
   input  nra_move_t                mv,
   input  logic [2*NIB_W-1:0]       load_word,
   input  logic [NIB_W-1:0]         acc_in,
   input  logic [NIB_W-1:0]         x_in,
   output logic [NIB_W*NUM_NIB-1:0] b_mv,
   output logic [NIB_W-1:0]         acc_out,
   output logic                     acc_we,
   output logic [NIB_W-1:0]         x_out,
   output logic                     x_we
);
   localparam int ADDR_W = NIB_W * NUM_NIB;
   localparam int MID_LO = NIB_W;
   localparam int TOP_LO = ADDR_W - NIB_W;

   always_comb begin
      b_mv = b_cur;
      if (mv.load)
         b_mv = ADDR_W'(load_word);
      if (mv.bu_acc)
         b_mv[TOP_LO +: NIB_W] = acc_in;
      if (mv.bm_x || mv.bm_swap)
         b_mv[MID_LO +: NIB_W] = x_in;
      if (mv.bl_swap)
         b_mv[0 +: NIB_W] = acc_in;
   end

   // return paths carry the pre-update nibbles
   assign acc_out = b_cur[0 +: NIB_W];
   assign acc_we  = mv.bl_swap;
   assign x_out   = b_cur[MID_LO +: NIB_W];
   assign x_we    = mv.bm_swap;

endmodule

// File: rtl/nra_step_stage.sv
module nra_step_stage
   import nram_addr_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int NUM_NIB = 3,
   parameter int XOR_W   = 3
) (
   input  logic [NIB_W*NUM_NIB-1:0] b_mv,
   input  nra_step_t                st,
   input  logic [NIB_W-1:0]         imm,
   output logic [NIB_W*NUM_NIB-1:0] b_nx,
   output logic                     skip_req
);
   localparam int ADDR_W = NIB_W * NUM_NIB;
   localparam int MID_LO = NIB_W;
   localparam logic [NIB_W-1:0] ONE  = NIB_W'(1);
   localparam logic [NIB_W-1:0] ALL1 = '1;

   logic [NIB_W-1:0] bm_src, bm_x, bl_src, bl_i, bl_d;

   assign bm_src = b_mv[MID_LO +: NIB_W];
   assign bl_src = b_mv[0 +: NIB_W];

   // XOR variant: full nibble or low XOR_W bits only
   generate
      if (XOR_W == NIB_W) begin : g_xor_full
         assign bm_x = st.xor_mid ? (bm_src ^ imm) : bm_src;
      end else begin : g_xor_part
         assign bm_x = st.xor_mid ?
            {bm_src[NIB_W-1:XOR_W], bm_src[XOR_W-1:0] ^ imm[XOR_W-1:0]} : bm_src;
      end
   endgenerate

   // increment, then decrement (decrement is the last update)
   assign bl_i = st.inc ? (bl_src + ONE) : bl_src;
   assign bl_d = st.dec ? (bl_i - ONE) : bl_i;

   always_comb begin
      b_nx = b_mv;
      b_nx[MID_LO +: NIB_W] = bm_x;
      b_nx[0 +: NIB_W]      = bl_d;
   end

   assign skip_req = (st.inc && (bl_i == '0))
                   | (st.dec && (bl_d == ALL1))
                   | (st.cmp && (bl_src == imm));

endmodule

// File: rtl/nra_bus_drive.sv
module nra_bus_drive #(
   parameter int NIB_W        = 4,
   parameter int NUM_NIB      = 3,
   parameter int SAG_KEEP_NIB = 1
) (
   input  logic [NIB_W*NUM_NIB-1:0] b_q,
   input  logic                     zero_hi,
   output logic [NIB_W*NUM_NIB-1:0] ram_addr
);
   generate
      for (genvar k = 0; k < NUM_NIB; k++) begin : g_nib
         if (k < SAG_KEEP_NIB) begin : g_keep
            assign ram_addr[k*NIB_W +: NIB_W] = b_q[k*NIB_W +: NIB_W];
         end else begin : g_gate
            assign ram_addr[k*NIB_W +: NIB_W] =
               zero_hi ? '0 : b_q[k*NIB_W +: NIB_W];
         end
      end
   endgenerate
endmodule

// File: rtl/nram_addr_unit.sv
module nram_addr_unit
   import nram_addr_pkg::*;
#(
   parameter int NIB_W        = 4,
   parameter int NUM_NIB      = 3,
   parameter int XOR_W        = 3,
   parameter int SAG_KEEP_NIB = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_load_pair,
   input  logic                     op_bu_from_acc,
   input  logic                     op_bm_from_x,
   input  logic                     op_bm_swap_x,
   input  logic                     op_bl_swap_acc,
   input  logic                     op_xor_mid,
   input  logic                     op_inc_low,
   input  logic                     op_dec_low,
   input  logic                     op_cmp_low,
   input  logic                     op_zero_page,
   input  logic [2*NIB_W-1:0]       load_word,
   input  logic [NIB_W-1:0]         imm,
   input  logic [NIB_W-1:0]         acc_in,
   input  logic [NIB_W-1:0]         x_in,
   output logic [NIB_W*NUM_NIB-1:0] b_out,
   output logic [NIB_W*NUM_NIB-1:0] ram_addr,
   output logic                     skip_req,
   output logic [NIB_W-1:0]         acc_out,
   output logic                     acc_we,
   output logic [NIB_W-1:0]         x_out,
   output logic                     x_we
);
   localparam int ADDR_W = NIB_W * NUM_NIB;

   // elaboration-time parameter checks
   generate
      if (NUM_NIB < 3) begin : g_bad_num
         $error("NUM_NIB must be at least 3");
      end
      if (XOR_W < 1 || XOR_W > NIB_W) begin : g_bad_xor
         $error("XOR_W must lie in 1..NIB_W");
      end
      if (SAG_KEEP_NIB < 1 || SAG_KEEP_NIB >= NUM_NIB) begin : g_bad_keep
         $error("SAG_KEEP_NIB must lie in 1..NUM_NIB-1");
      end
   endgenerate

   logic [ADDR_W-1:0] b_q, b_mv, b_nx;
   logic              zero_pend;
   nra_move_t         mv;
   nra_step_t         st;

   assign mv = '{load: op_load_pair, bu_acc: op_bu_from_acc, bm_x: op_bm_from_x,
                 bm_swap: op_bm_swap_x, bl_swap: op_bl_swap_acc};
   assign st = '{xor_mid: op_xor_mid, inc: op_inc_low, dec: op_dec_low,
                 cmp: op_cmp_low};

   nra_move_stage #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_move (
      .b_cur     (b_q),
      .mv        (mv),
      .load_word (load_word),
      .acc_in    (acc_in),
      .x_in      (x_in),
      .b_mv      (b_mv),
      .acc_out   (acc_out),
      .acc_we    (acc_we),
      .x_out     (x_out),
      .x_we      (x_we)
   );

   nra_step_stage #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .XOR_W(XOR_W)) u_step (
      .b_mv     (b_mv),
      .st       (st),
      .imm      (imm),
      .b_nx     (b_nx),
      .skip_req (skip_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q       <= '0;
         zero_pend <= 1'b0;
      end else begin
         b_q       <= b_nx;
         zero_pend <= op_zero_page;
      end
   end

   nra_bus_drive #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB),
                   .SAG_KEEP_NIB(SAG_KEEP_NIB)) u_bus (
      .b_q      (b_q),
      .zero_hi  (zero_pend),
      .ram_addr (ram_addr)
   );

   assign b_out = b_q;

endmodule

// File: rtl/nram_addr_unit_chk.sv
module nram_addr_unit_chk #(
   parameter int NIB_W        = 4,
   parameter int NUM_NIB      = 3,
   parameter int XOR_W        = 3,
   parameter int SAG_KEEP_NIB = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     op_load_pair,
   input logic                     op_bu_from_acc,
   input logic                     op_bm_from_x,
   input logic                     op_bm_swap_x,
   input logic                     op_bl_swap_acc,
   input logic                     op_xor_mid,
   input logic                     op_inc_low,
   input logic                     op_dec_low,
   input logic                     op_cmp_low,
   input logic                     op_zero_page,
   input logic [2*NIB_W-1:0]       load_word,
   input logic [NIB_W-1:0]         imm,
   input logic [NIB_W-1:0]         acc_in,
   input logic [NIB_W*NUM_NIB-1:0] b_out,
   input logic [NIB_W*NUM_NIB-1:0] ram_addr,
   input logic                     skip_req
);
   localparam int ADDR_W = NIB_W * NUM_NIB;
   localparam int KEEP_W = SAG_KEEP_NIB * NIB_W;

   logic [9:0]       ops;
   logic [NIB_W-1:0] bl, bm, bu;
   logic             one_op;

   assign ops = {op_load_pair, op_bu_from_acc, op_bm_from_x, op_bm_swap_x,
                 op_bl_swap_acc, op_xor_mid, op_inc_low, op_dec_low,
                 op_cmp_low, op_zero_page};
   assign one_op = ($countones(ops) == 1);
   assign bl = b_out[0 +: NIB_W];
   assign bm = b_out[NIB_W +: NIB_W];
   assign bu = b_out[ADDR_W-NIB_W +: NIB_W];

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_load_pair && one_op) |=> (b_out == ADDR_W'($past(load_word))));

   p_xor_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_xor_mid && one_op) |=>
         (bm == ($past(bm) ^ NIB_W'($past(imm[XOR_W-1:0]))))
         && $stable(bl) && $stable(bu));

   p_inc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_inc_low && one_op) |-> (skip_req == (bl == '1)));

   p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_inc_low && one_op) |=> (bl == NIB_W'($past(bl) + 1'b1)) && $stable(bm));

   p_dec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_dec_low && one_op) |-> (skip_req == (bl == '0)));

   p_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_cmp_low && one_op) |-> (skip_req == (bl == imm)) ##1 $stable(b_out));

   p_zero_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_zero_page) |->
         (ram_addr[ADDR_W-1:KEEP_W] == '0) && (ram_addr[KEEP_W-1:0] == b_out[KEEP_W-1:0]));

   p_bus_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(op_zero_page) |-> (ram_addr == b_out));

   p_bu_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_bu_from_acc && one_op) |=> (bu == $past(acc_in)));

   p_skip_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_inc_low || op_dec_low || op_cmp_low) |-> !skip_req);

endmodule

bind nram_addr_unit nram_addr_unit_chk #(
   .NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .XOR_W(XOR_W), .SAG_KEEP_NIB(SAG_KEEP_NIB)
) u_chk (.*);

// File: tb/nram_addr_unit_bench.sv
module nram_addr_unit_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_load_pair = 0, op_bu_from_acc = 0, op_bm_from_x = 0, op_bm_swap_x = 0;
   logic op_bl_swap_acc = 0, op_xor_mid = 0, op_inc_low = 0, op_dec_low = 0;
   logic op_cmp_low = 0, op_zero_page = 0;
   logic [7:0]  load_word = '0;
   logic [3:0]  imm = '0, acc_in = '0, x_in = '0;
   logic [11:0] b_out, ram_addr;
   logic        skip_req, acc_we, x_we;
   logic [3:0]  acc_out, x_out;

   always #5 clk = ~clk;

   nram_addr_unit u_nram_addr_unit (.*);

   typedef struct {
      int          req;
      logic [11:0] b;
      logic [11:0] bus;
      logic        skip;
      logic        acc_we;
      logic [3:0]  acc_val;
      logic        x_we;
      logic [3:0]  x_val;
   } exp_t;

   exp_t exp_q[$];
   exp_t e;
   int   checks = 0, fails = 0;
   bit   done = 0;

   // next-cycle strobe requests set by the sequence, applied by go()
   logic n_load, n_bu, n_bmx, n_bmsw, n_blsw, n_xor, n_inc, n_dec, n_cmp, n_zp;
   logic [7:0]  n_lw;
   logic [3:0]  n_imm, n_acc, n_x;
   logic [11:0] mb = '0;
   logic        mzp = 1'b0;

   task automatic clear_req();
      {n_load, n_bu, n_bmx, n_bmsw, n_blsw, n_xor, n_inc, n_dec, n_cmp, n_zp} = '0;
      n_lw = '0; n_imm = '0; n_acc = '0; n_x = '0;
   endtask

   task automatic chk(input int req, input string what,
                      input logic [11:0] act, input logic [11:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // driver: applies strobes, pushes expectation for this cycle, steps model
   task automatic go(input int req);
      exp_t        it;
      logic [11:0] nx;
      logic        sk;
      @(posedge clk); #2;
      op_load_pair = n_load; op_bu_from_acc = n_bu; op_bm_from_x = n_bmx;
      op_bm_swap_x = n_bmsw; op_bl_swap_acc = n_blsw; op_xor_mid = n_xor;
      op_inc_low = n_inc; op_dec_low = n_dec; op_cmp_low = n_cmp;
      op_zero_page = n_zp; load_word = n_lw; imm = n_imm; acc_in = n_acc; x_in = n_x;
      it.req = req;
      it.b = mb;
      it.bus = mzp ? {8'h00, mb[3:0]} : mb;
      it.acc_we = n_blsw; it.acc_val = mb[3:0];
      it.x_we = n_bmsw;   it.x_val = mb[7:4];
      nx = mb;
      if (n_load) nx = {4'h0, n_lw};
      if (n_bu) nx[11:8] = n_acc;
      if (n_bmx || n_bmsw) nx[7:4] = n_x;
      if (n_blsw) nx[3:0] = n_acc;
      if (n_xor) nx[6:4] = nx[6:4] ^ n_imm[2:0];
      sk = n_cmp && (nx[3:0] == n_imm);
      if (n_inc) begin nx[3:0] = nx[3:0] + 4'd1; sk = sk | (nx[3:0] == 4'h0); end
      if (n_dec) begin nx[3:0] = nx[3:0] - 4'd1; sk = sk | (nx[3:0] == 4'hF); end
      it.skip = sk;
      exp_q.push_back(it);
      mb = nx;
      mzp = n_zp;
      clear_req();
   endtask

   // monitor: compares one expectation per cycle at the falling edge
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         chk(e.req, "b_out", b_out, e.b);
         chk(e.req == 7 ? 7 : 8, "ram_addr", ram_addr, e.bus);
         chk(e.req, "skip_req", {11'h0, skip_req}, {11'h0, e.skip});
         chk(10, "acc_we", {11'h0, acc_we}, {11'h0, e.acc_we});
         chk(10, "x_we", {11'h0, x_we}, {11'h0, e.x_we});
         if (e.acc_we) chk(10, "acc_out", {8'h0, acc_out}, {8'h0, e.acc_val});
         if (e.x_we)   chk(10, "x_out", {8'h0, x_out}, {8'h0, e.x_val});
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      clear_req();
      repeat (2) @(posedge clk);
      #2;
      // R1: state while reset is held
      chk(1, "reset b_out", b_out, 12'h000);
      chk(1, "reset ram_addr", ram_addr, 12'h000);
      chk(1, "reset skip", {11'h0, skip_req}, 12'h000);
      rst_n = 1'b1;
      go(1);                                              // R1 after release
      n_load = 1; n_lw = 8'hA7; go(2);                    // R2
      n_bu = 1; n_acc = 4'h5; go(9);                      // R9 high nibble
      n_load = 1; n_lw = 8'h3C; go(2);                    // R2 clears high nibble
      n_xor = 1; n_imm = 4'hD; go(3);                     // R3 imm bit 3 unused
      n_bmx = 1; n_x = 4'hE; go(9);                       // R9 middle from X
      n_xor = 1; n_imm = 4'h3; go(3);                     // R3 bit 3 kept
      n_blsw = 1; n_acc = 4'hF; go(10);                   // R10 low swap
      n_inc = 1; go(4);                                   // R4 wrap, skip
      n_inc = 1; go(4);                                   // R4 no skip
      n_dec = 1; go(5);                                   // R5 to zero
      n_dec = 1; go(5);                                   // R5 wrap, skip
      n_xor = 1; n_imm = 4'h1; n_dec = 1; go(5);          // R5 with XOR
      n_cmp = 1; n_imm = 4'hE; go(6);                     // R6 equal
      n_cmp = 1; n_imm = 4'h3; go(6);                     // R6 unequal
      n_zp = 1; go(7);                                    // R7 strobe
      go(7);                                              // R7 override cycle
      go(8);                                              // R8 normal again
      n_bmsw = 1; n_x = 4'h2; go(10);                     // R10 middle swap
      n_bu = 1; n_acc = 4'h9; go(9);                      // R9
      n_zp = 1; go(7);                                    // R7
      n_inc = 1; go(7);                                   // R7 override with update
      go(8);                                              // R8
      go(11); go(11); go(11);                             // R11 quiet cycles
      @(posedge clk); @(posedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule